// File: doc/BRIEF.md
# Smart card session sequencer

This block controls the contacts of one smart card slot. When the host pulls its active-low session command low, the block starts a timed power-up of the card. It raises a request for the fast oscillator, then turns on the card supply, the I/O lines, the card clock and the card reset, in that order. When the host releases the command, the block powers the card down in a different order and returns to idle. If a fault occurs during a session, the block runs the same power-down sequence on its own and pulls the status line low.

All sequence timing comes from a tick input driven by the internal oscillator. The base unit T is `TICKS_PER_T` ticks (64 by default), and every milestone sits on a half-unit boundary. Outside a session, the status line shows whether a card is present, using a debounce of `DEB_TICKS` ticks. A power-on hold of `POR_TICKS` ticks blocks all commands after reset, and the same hold restarts whenever the supply-low flag is raised. The analog supply, the level shifters and the current sensing are outside this block. They appear here only as enable outputs and fault inputs.

Top module: `scs_session_top`

## Requirements
- R1: While reset is asserted and just after it is released, every card enable, the card reset and the fast-oscillator request are low, and the status line is low.
- R2: After reset, and again after any cycle with `uv_fault_i` high, a session command is ignored until `POR_TICKS` ticks have been counted.
- R3: An accepted activation raises `fast_osc_o` at once. With n ticks counted since acceptance and H = TICKS_PER_T/2, `vcc_en_o` is high once n/H >= 1, `io_en_o` once n/H >= 9, and the session is fully on once n/H >= 15.
- R4: If `rst_req_i` is low when activation is accepted, `clk_en_o` rises together with `io_en_o`.
- R5: If `rst_req_i` is high when activation is accepted, `clk_en_o` rises only once `rst_req_i` is low and n/H >= 9, or else at full on. After full on, `rst_req_i` has no effect on the clock.
- R6: `card_rst_o` stays low during activation. After full on it equals `rst_req_i`.
- R7: When the command goes high during a session, `card_rst_o` drops at once. With m ticks counted since then, `clk_en_o` drops at m/H >= 1, `io_en_o` at m/H >= 2, `vcc_en_o` at m/H >= 3, and `fast_osc_o` at m/H >= 5, where the block returns to idle.
- R8: During activation or full on, an overcurrent, overtemperature or supply-low flag pulls the status line low and starts the R7 power-down sequence. The status line stays low until the block is idle and the command is high.
- R9: If the card is removed during a session, power-down starts on the next clock edge without any debounce, and the status line goes low.
- R10: Outside a fault, the status line goes high only after the card has been present for `DEB_TICKS` ticks without a break. It falls within one cycle after the card is removed.
- R11: Outside a session, the overcurrent and overtemperature flags have no effect on the outputs.
- R12: A new activation needs the command to have been seen high since the last acceptance, and it needs a debounced card. After a fault power-down with the command still low, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per internal oscillator period |
| cmd_n_i | input | 1 | Session command from the host, low means session requested |
| rst_req_i | input | 1 | Card reset level requested by the host |
| card_present_i | input | 1 | Raw card-presence switch, high means a card is present |
| oc_fault_i | input | 1 | Overcurrent flag |
| ot_fault_i | input | 1 | Overtemperature flag |
| uv_fault_i | input | 1 | Supply-below-threshold flag |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Card I/O line enable |
| clk_en_o | output | 1 | Card clock gate enable |
| card_rst_o | output | 1 | Card reset contact level |
| fast_osc_o | output | 1 | Fast internal oscillator request |
| status_n_o | output | 1 | Status and interrupt line to the host, low means no card or a fault |

## Verification
The bench checks every output after every tick of a complete activation and power-down. It runs the activation with the host reset low, and with the host reset high while sweeping the tick at which the host reset is released through every position before, inside and after the clock window. This sweep separates a clock started by the I/O milestone, by the host reset release, or by the full-on transition. Each fault source, including card removal, is injected at full on. These runs show that the power-down timing matches the host-requested one, that the status line stays low and that the block does not rearm until the command goes high. Presence glitches, supply-low pulses outside a session and overcurrent or overtemperature pulses outside a session test the debounce, the power-on hold and the flags that must be ignored.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_ON, ST_DEACT} seq_st_e;

  // milestones in half-units of T, counted from acceptance (t0)
  localparam int unsigned H_VCC     = 1;   // supply on, t1 = t0 + 0.5T
  localparam int unsigned H_RAMP    = 4;   // supply ramp done, t1 + 1.5T
  localparam int unsigned H_IO      = 9;   // t1 + 4T
  localparam int unsigned H_RST     = 15;  // t1 + 7T
  // power-down milestones in half-units, counted from the command rising
  localparam int unsigned H_CLK_OFF = 1;
  localparam int unsigned H_IO_OFF  = 2;
  localparam int unsigned H_VCC_OFF = 3;
  localparam int unsigned H_DONE    = 5;
endpackage

// File: rtl/scs_tick_timer.sv
module scs_tick_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LIMIT));
  p_restart_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o);
endmodule

// File: rtl/scs_seq.sv
module scs_seq
  import scs_pkg::*;
#(
  parameter int unsigned TICKS_PER_T = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cmd_n_i,
  input  logic rst_req_i,
  input  logic card_present_i,
  input  logic oc_fault_i,
  input  logic ot_fault_i,
  input  logic uv_fault_i,
  input  logic por_done_i,
  input  logic pres_db_i,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o,
  output logic fast_osc_o,
  output logic fault_o
);
  localparam int unsigned HALF = TICKS_PER_T / 2;
  localparam int unsigned TW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned HW   = $clog2(H_RST + 1);

  seq_st_e       st_q;
  logic [TW-1:0] tcnt_q;
  logic [HW-1:0] h_q;
  logic vcc_q, io_q, clk_q, rst_en_q, osc_q, fault_q, armed_q, alt_q;

  logic in_sess, fault_hit, half_wrap;
  assign in_sess   = (st_q == ST_ACT) || (st_q == ST_ON);
  assign fault_hit = in_sess && (oc_fault_i || ot_fault_i || uv_fault_i || !card_present_i);
  assign half_wrap = tick_i && (tcnt_q == TW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; tcnt_q <= '0; h_q <= '0;
      vcc_q <= 1'b0; io_q <= 1'b0; clk_q <= 1'b0; rst_en_q <= 1'b0;
      osc_q <= 1'b0; fault_q <= 1'b0; armed_q <= 1'b0; alt_q <= 1'b0;
    end else begin
      if (cmd_n_i) armed_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (cmd_n_i) fault_q <= 1'b0;
          if (!cmd_n_i && armed_q && por_done_i && pres_db_i) begin
            st_q <= ST_ACT; tcnt_q <= '0; h_q <= '0;
            osc_q <= 1'b1; armed_q <= 1'b0; alt_q <= rst_req_i;
          end
        end
        ST_ACT, ST_ON: begin
          if (fault_hit || cmd_n_i) begin
            st_q <= ST_DEACT; tcnt_q <= '0; h_q <= '0; rst_en_q <= 1'b0;
            if (fault_hit) fault_q <= 1'b1;
          end else if (st_q == ST_ACT) begin
            if (h_q >= HW'(H_VCC)) vcc_q <= 1'b1;
            if (h_q >= HW'(H_IO)) begin
              io_q <= 1'b1;
              if (!alt_q || !rst_req_i) clk_q <= 1'b1;
            end
            if (half_wrap) begin
              tcnt_q <= '0;
              if (h_q == HW'(H_RST - 1)) begin
                st_q <= ST_ON; rst_en_q <= 1'b1;
                vcc_q <= 1'b1; io_q <= 1'b1; clk_q <= 1'b1;
              end else h_q <= h_q + 1'b1;
            end else if (tick_i) tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_DEACT: begin
          if (h_q >= HW'(H_CLK_OFF)) clk_q <= 1'b0;
          if (h_q >= HW'(H_IO_OFF))  io_q  <= 1'b0;
          if (h_q >= HW'(H_VCC_OFF)) vcc_q <= 1'b0;
          if (half_wrap) begin
            tcnt_q <= '0;
            if (h_q == HW'(H_DONE - 1)) begin
              st_q <= ST_IDLE; osc_q <= 1'b0;
            end else h_q <= h_q + 1'b1;
          end else if (tick_i) tcnt_q <= tcnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vcc_en_o   = vcc_q;
  assign io_en_o    = io_q;
  assign clk_en_o   = clk_q;
  assign card_rst_o = rst_en_q & rst_req_i;
  assign fast_osc_o = osc_q;
  assign fault_o    = fault_q;

  p_io_needs_vcc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o);
  p_vcc_needs_osc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_en_o |-> fast_osc_o);
  p_rst_after_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> (io_en_o && clk_en_o));
  p_cmd_drops_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sess && cmd_n_i) |=> !card_rst_o);
  p_fault_deact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_hit |=> (st_q == ST_DEACT) && fault_o);
  p_por_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && !por_done_i) |=> (st_q == ST_IDLE));
  p_rearm_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && !armed_q) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/scs_session_top.sv
module scs_session_top #(
  parameter int unsigned TICKS_PER_T = 64,
  parameter int unsigned POR_TICKS   = 563,
  parameter int unsigned DEB_TICKS   = 20480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cmd_n_i,
  input  logic rst_req_i,
  input  logic card_present_i,
  input  logic oc_fault_i,
  input  logic ot_fault_i,
  input  logic uv_fault_i,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o,
  output logic fast_osc_o,
  output logic status_n_o
);
  logic por_done, pres_db, fault;

  scs_tick_timer #(.LIMIT(POR_TICKS)) u_por (
    .clk_i, .rst_ni, .tick_i, .restart_i(uv_fault_i), .done_o(por_done));

  scs_tick_timer #(.LIMIT(DEB_TICKS)) u_deb (
    .clk_i, .rst_ni, .tick_i, .restart_i(!card_present_i), .done_o(pres_db));

  scs_seq #(.TICKS_PER_T(TICKS_PER_T)) u_seq (
    .clk_i, .rst_ni, .tick_i, .cmd_n_i, .rst_req_i, .card_present_i,
    .oc_fault_i, .ot_fault_i, .uv_fault_i,
    .por_done_i(por_done), .pres_db_i(pres_db),
    .vcc_en_o, .io_en_o, .clk_en_o, .card_rst_o, .fast_osc_o,
    .fault_o(fault));

  assign status_n_o = pres_db && !fault;

  p_status_low_on_removal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !card_present_i |=> !status_n_o);
endmodule

// File: tb/scs_session_top_tb_top.sv
`timescale 1ns/1ps
module scs_session_top_tb_top;
  localparam int TPT = 8;
  localparam int HALF = TPT / 2;
  localparam int POR = 5;
  localparam int DEB = 6;
  localparam int ON_N = 15 * HALF;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cmd_n = 1'b1, rst_req = 1'b0;
  logic present = 1'b0, oc = 1'b0, ot = 1'b0, uv = 1'b0;
  logic vcc_en, io_en, clk_en, card_rst, fast_osc, status_n;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scs_session_top #(.TICKS_PER_T(TPT), .POR_TICKS(POR), .DEB_TICKS(DEB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_n_i(cmd_n), .rst_req_i(rst_req),
    .card_present_i(present), .oc_fault_i(oc), .ot_fault_i(ot), .uv_fault_i(uv),
    .vcc_en_o(vcc_en), .io_en_o(io_en), .clk_en_o(clk_en), .card_rst_o(card_rst),
    .fast_osc_o(fast_osc), .status_n_o(status_n));

  // packed as {vcc, io, clk, rst, osc, status}
  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {vcc_en, io_en, clk_en, card_rst, fast_osc, status_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [5:0] exp_act(int n, bit alt, int r, logic rq);
    int h;
    h = n / HALF;
    if (n >= ON_N) return {3'b111, rq, 2'b11};
    return {logic'(h >= 1), logic'(h >= 9), logic'(h >= 9 && (!alt || r < n)), 1'b0, 2'b11};
  endfunction

  function automatic logic [5:0] exp_deact(int m, logic st);
    int h;
    h = m / HALF;
    if (h >= 5) return {5'b00000, st};
    return {logic'(h < 3), logic'(h < 2), logic'(h < 1), 1'b0, 1'b1, st};
  endfunction

  task automatic run_act(input bit alt, input int r);
    rst_req = alt;
    cmd_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n <= ON_N; n++) begin
      chk(alt ? "R5 R6 alt activation" : "R3 R4 R6 activation", exp_act(n, alt, r, rst_req));
      if (n == r) rst_req = 1'b0;
      if (n < ON_N) do_tick();
    end
  endtask

  task automatic run_deact(input logic st);
    cmd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 deactivation start", {4'b1110, 1'b1, st});
    for (int m = 1; m <= 5 * HALF; m++) begin
      do_tick();
      chk("R7 deactivation", exp_deact(m, st));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 6'b000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 6'b000000);

    // debounce from insertion
    present = 1'b1;
    for (int n = 1; n <= DEB + 2; n++) begin
      do_tick();
      chk("R10 debounce rise", {5'b00000, logic'(n >= DEB)});
    end
    present = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 immediate fall", 6'b000000);
    present = 1'b1;
    for (int n = 1; n <= DEB; n++) begin
      do_tick();
      chk("R10 debounce restart", {5'b00000, logic'(n >= DEB)});
    end

    // ignored flags outside a session
    oc = 1'b1; @(negedge clk); oc = 1'b0;
    ot = 1'b1; @(negedge clk); ot = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 idle faults ignored", 6'b000001);

    // power-on hold restarted by supply-low flag
    uv = 1'b1; @(negedge clk); uv = 1'b0;
    cmd_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n <= POR; n++) begin
      chk("R2 power-on hold", {4'b0000, logic'(n >= POR), 1'b1});
      if (n < POR) do_tick();
    end
    cmd_n = 1'b1;
    repeat (5 * HALF + 1) do_tick();
    chk("R7 aborted activation idle", 6'b000001);

    // normal path, then host reset followed after full on
    run_act(1'b0, 1000);
    for (int k = 0; k < 4; k++) begin
      rst_req = ~rst_req;
      repeat (2) @(negedge clk);
      chk("R6 R5 reset follows, clock unaffected", {3'b111, rst_req, 2'b11});
    end
    rst_req = 1'b0;
    run_deact(1'b1);

    // alternate path: sweep host reset release
    for (int r = 0; r <= ON_N + 3; r++) begin
      run_act(1'b1, r);
      rst_req = 1'b0;
      run_deact(1'b1);
    end

    // faults at full on
    for (int f = 0; f < 4; f++) begin
      run_act(1'b0, 1000);
      rst_req = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 reset high before fault", 6'b111111);
      case (f)
        0: oc = 1'b1;
        1: ot = 1'b1;
        2: uv = 1'b1;
        default: present = 1'b0;
      endcase
      @(negedge clk);
      oc = 1'b0; ot = 1'b0; uv = 1'b0;
      @(negedge clk);
      chk(f == 3 ? "R9 removal deactivation" : "R8 fault deactivation", 6'b111010);
      for (int m = 1; m <= 5 * HALF; m++) begin
        do_tick();
        chk(f == 3 ? "R9 removal sequence" : "R8 fault sequence", exp_deact(m, 1'b0));
      end
      rst_req = 1'b0;
      present = 1'b1;
      repeat (10) do_tick();
      chk("R12 no restart while command low", 6'b000000);
      cmd_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 status restored", 6'b000001);
      cmd_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R12 rearmed activation", 6'b000011);
      cmd_n = 1'b1;
      repeat (5 * HALF + 1) do_tick();
      chk("R12 back to idle", 6'b000001);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule